// File: doc/BRIEF.md
# ARGB Pixel Expander

This block takes one pixel at a time in any of twelve source encodings and produces the same pixel as a 32-bit word with alpha, red, green and blue in one byte each. On the way it can replace the alpha byte with a fixed value, or scale the alpha by that value. It can then complement the alpha and exchange the red and blue bytes. Indexed encodings are resolved through an internal colour table. Alpha-only encodings take their colour from a configuration input.

The colour table has `2**IDX_W` entries and is filled by a load sequence. A start pulse sets the index of the last entry to fill and selects the entry format. Data words then fill entries 0, 1, 2 and onward, one word per valid beat. A separate register-side port can read and write single entries while no load is running. Pixel input and output both use valid/ready handshakes. A pixel accepted at the input appears at the output two clock edges later when the output is not stalled. The configuration inputs must be held steady while pixels are in flight.

Top module: `argb_expander`

## Requirements
- R1: Output layout is alpha [31:24], red [23:16], green [15:8], blue [7:0]. The format code selects the input layout:
  - 0: the word passes through unchanged.
  - 1: the colour is in [23:0] with the same byte order.
  - 2: red is in [15:11], green in [10:5] and blue in [4:0].
  - 3: alpha is in [15], red in [14:10], green in [9:5] and blue in [4:0].
  - 4: the nibbles of [15:0] hold alpha, red, green and blue, from the top nibble down.
  - 11: the three bytes of [23:0] pass straight to the colour bytes.
  - Codes 1, 2 and 11 give alpha 0xFF.
- R2: Channels narrower than 8 bits are widened by repeating their top bits below them: v*8+v/4 for 5 bits, v*4+v/16 for 6 bits, v*17 for 4 bits. A 1-bit alpha gives 0x00 or 0xFF.
- R3: Indexed formats read one table entry:
  - Code 5 uses index [7:0] and takes the whole entry.
  - Code 6 uses index [3:0] and alpha [7:4], widened.
  - Code 7 uses index [7:0] and alpha [15:8].
  - Code 8 uses a 4-bit index and takes the whole entry.
  - Codes 6 and 7 keep only the entry's colour bytes.
- R4: Alpha-only formats take red, green and blue from `cfg_color` ([23:16], [15:8], [7:0]). Code 9 takes a 4-bit alpha, widened. Code 10 takes its alpha from [7:0].
- R5: For codes 8 and 9, each accepted word gives two output pixels: first from bits [3:0], then from bits [7:4]. `in_ready` is low in the cycle after such an acceptance.
- R6: Alpha mode is applied after decoding:
  - 0 and 3 keep the decoded alpha.
  - 1 replaces it with `cfg_alpha`.
  - 2 gives (a*`cfg_alpha`+127)/255, rounded down.
- R7: When `cfg_ainv` is set, the alpha produced by R6 is replaced by 255 minus that alpha.
- R8: When `cfg_rbswap` is set, the output red and blue bytes are exchanged.
- R9: Format codes 12 to 15 decode to 0x00000000 before R6 to R8 are applied.
- R10: Output pixels appear in input order, with none lost or repeated, under any `out_ready` pattern. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.
- R11: Table load:
  - A `ld_start` pulse while idle captures `ld_last` and `ld_rgb` and raises `ld_busy`.
  - Each `ld_valid` beat writes the next entry, starting at entry 0.
  - `ld_busy` falls after the beat that writes entry `ld_last`.
  - With `ld_rgb` set, an entry stores 0xFF over `ld_data[23:0]`.
  - Entries above `ld_last` keep their contents.
  - `ld_start` is ignored while busy, and `in_ready` is low while busy.
- R12: Register-side access while idle works as follows:
  - A write with `cpu_en` and `cpu_we` stores `cpu_wdata`.
  - A read returns the entry on `cpu_rdata` one edge later.
  - An access while `ld_busy` is high has no effect on the table or on `cpu_rdata`, and pulses `cpu_err` for one cycle instead.
- R13: After reset, `out_valid`, `ld_busy` and `cpu_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_fmt | input | 4 | Source format code |
| cfg_amode | input | 2 | Alpha mode |
| cfg_alpha | input | 8 | Fixed alpha for replace/scale |
| cfg_ainv | input | 1 | Complement final alpha |
| cfg_rbswap | input | 1 | Exchange red and blue |
| cfg_color | input | 24 | Colour for alpha-only formats |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | 32 | Input pixel word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel taken |
| out_data | output | 32 | Expanded pixel |
| ld_start | input | 1 | Begin table load |
| ld_last | input | IDX_W | Index of last entry to load |
| ld_rgb | input | 1 | Entries are 24-bit colour |
| ld_valid | input | 1 | Load word valid |
| ld_data | input | 32 | Load word |
| ld_busy | output | 1 | Table load in progress |
| cpu_en | input | 1 | Register-side access |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | IDX_W | Entry index |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data |
| cpu_err | output | 1 | Access refused during load |

## Verification
Each format is first swept under all twelve combinations of alpha mode, inversion and swap with pseudo-random words. This separates errors in decode placement from errors in the post-processing order. The 16-bit packed formats are then stepped finely across their whole input range, and the 8-bit and nibble formats are swept exhaustively. These sweeps expose wrong replication bits or wrong table indices that random values might miss. The scaling mode gets an exhaustive alpha sweep at several fixed alphas, which exposes rounding off by one. A table reload with 24-bit entries over a short range shows whether untouched entries keep their contents and whether nibble indexing picks the right half.

// File: rtl/argb_expander.sv
module argb_expander #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cfg_fmt,
  input  logic [1:0]       cfg_amode,
  input  logic [7:0]       cfg_alpha,
  input  logic             cfg_ainv,
  input  logic             cfg_rbswap,
  input  logic [23:0]      cfg_color,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  input  logic             ld_start,
  input  logic [IDX_W-1:0] ld_last,
  input  logic             ld_rgb,
  input  logic             ld_valid,
  input  logic [31:0]      ld_data,
  output logic             ld_busy,
  input  logic             cpu_en,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_addr,
  input  logic [31:0]      cpu_wdata,
  output logic [31:0]      cpu_rdata,
  output logic             cpu_err
);

  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [7:0] x4(input logic [3:0] v);
    return {v, v};
  endfunction
  function automatic logic [7:0] x5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction
  function automatic logic [7:0] x6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  logic [31:0]      lut [DEPTH];
  logic [IDX_W-1:0] ld_cnt, ld_end;
  logic             ld_fmt_rgb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_busy    <= 1'b0;
      ld_cnt     <= '0;
      ld_end     <= '0;
      ld_fmt_rgb <= 1'b0;
    end else if (!ld_busy) begin
      if (ld_start) begin
        ld_busy    <= 1'b1;
        ld_cnt     <= '0;
        ld_end     <= ld_last;
        ld_fmt_rgb <= ld_rgb;
      end
    end else if (ld_valid) begin
      ld_cnt <= ld_cnt + 1'b1;
      if (ld_cnt == ld_end) ld_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_busy && ld_valid)
      lut[ld_cnt] <= ld_fmt_rgb ? {8'hFF, ld_data[23:0]} : ld_data;
    else if (!ld_busy && cpu_en && cpu_we)
      lut[cpu_addr] <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
      cpu_err   <= 1'b0;
    end else begin
      cpu_err <= cpu_en && ld_busy;
      if (cpu_en && !cpu_we && !ld_busy) cpu_rdata <= lut[cpu_addr];
    end
  end

  logic        adv, take, nib_pend, is4, s1_v;
  logic [3:0]  nib_hi;
  logic [31:0] src, raw, ent, s1_px;
  logic [7:0]  idx8;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv && !nib_pend && !ld_busy;
  assign is4      = (cfg_fmt == 4'd8) || (cfg_fmt == 4'd9);
  assign take     = nib_pend || (in_valid && in_ready);
  assign src      = nib_pend ? {28'd0, nib_hi} : in_data;
  assign idx8     = (cfg_fmt == 4'd6 || cfg_fmt == 4'd8) ? {4'd0, src[3:0]} : src[7:0];
  assign ent      = lut[IDX_W'(idx8)];

  always_comb begin
    case (cfg_fmt)
      4'd0:       raw = src;
      4'd1, 4'd11: raw = {8'hFF, src[23:0]};
      4'd2:       raw = {8'hFF, x5(src[15:11]), x6(src[10:5]), x5(src[4:0])};
      4'd3:       raw = {{8{src[15]}}, x5(src[14:10]), x5(src[9:5]), x5(src[4:0])};
      4'd4:       raw = {x4(src[15:12]), x4(src[11:8]), x4(src[7:4]), x4(src[3:0])};
      4'd5, 4'd8: raw = ent;
      4'd6:       raw = {x4(src[7:4]), ent[23:0]};
      4'd7:       raw = {src[15:8], ent[23:0]};
      4'd9:       raw = {x4(src[3:0]), cfg_color};
      4'd10:      raw = {src[7:0], cfg_color};
      default:    raw = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_pend <= 1'b0;
      nib_hi   <= '0;
      s1_v     <= 1'b0;
      s1_px    <= '0;
    end else if (adv) begin
      s1_v <= take;
      if (take) s1_px <= raw;
      if (nib_pend) nib_pend <= 1'b0;
      else if (in_valid && in_ready && is4) begin
        nib_pend <= 1'b1;
        nib_hi   <= in_data[7:4];
      end
    end
  end

  logic [15:0] prod, mq;
  logic [7:0]  a_sel, a_fin;

  assign prod = 16'(s1_px[31:24]) * 16'(cfg_alpha) + 16'd128;
  assign mq   = prod + {8'd0, prod[15:8]};

  always_comb begin
    case (cfg_amode)
      2'd1:    a_sel = cfg_alpha;
      2'd2:    a_sel = mq[15:8];
      default: a_sel = s1_px[31:24];
    endcase
  end
  assign a_fin = cfg_ainv ? ~a_sel : a_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= s1_v;
      if (s1_v)
        out_data <= cfg_rbswap ? {a_fin, s1_px[7:0], s1_px[15:8], s1_px[23:16]}
                               : {a_fin, s1_px[23:0]};
    end
  end

endmodule

// File: rtl/argb_expander_chk.sv
module argb_expander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cfg_fmt,
  input logic [1:0]  cfg_amode,
  input logic [7:0]  cfg_alpha,
  input logic        cfg_ainv,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        ld_busy,
  input logic        cpu_en,
  input logic        cpu_err
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

  AST_LOAD_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_busy |-> !in_ready); // R11

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> $past(cpu_en && ld_busy)); // R12

  AST_NIBBLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (cfg_fmt == 4'd8 || cfg_fmt == 4'd9) |=> !in_ready); // R5

  AST_REPLACE_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_amode == 2'd1 && !cfg_ainv |-> out_data[31:24] == cfg_alpha); // R6

endmodule

bind argb_expander argb_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_amode(cfg_amode),
  .cfg_alpha(cfg_alpha), .cfg_ainv(cfg_ainv), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .ld_busy(ld_busy), .cpu_en(cpu_en), .cpu_err(cpu_err)
);

// File: tb/argb_expander_test.sv
module argb_expander_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [3:0] cfg_fmt = '0;
  logic [1:0] cfg_amode = '0;
  logic [7:0] cfg_alpha = '0;
  logic cfg_ainv = 1'b0, cfg_rbswap = 1'b0;
  logic [23:0] cfg_color = 24'h3C_81_E7;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic out_valid, out_ready = 1'b1;
  logic [31:0] out_data;
  logic ld_start = 1'b0, ld_rgb = 1'b0, ld_valid = 1'b0, ld_busy;
  logic [7:0] ld_last = '0;
  logic [31:0] ld_data = '0;
  logic cpu_en = 1'b0, cpu_we = 1'b0, cpu_err;
  logic [7:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;

  argb_expander uut (.*);

  int checks = 0, fails = 0;
  logic [31:0] lut_m [256];
  logic [31:0] exp_q [256];
  string tag_q [256];
  int wr = 0, rd = 0;
  logic [31:0] rng = 32'h1357_9BDF;
  logic [31:0] rrng = 32'h2468_ACE1;
  logic done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rnd(output logic [31:0] v);
    rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
    v = rng;
  endtask

  function automatic logic [31:0] raw(input logic [3:0] f, input logic [31:0] w);
    int r, g, b, a;
    case (f)
      4'd0: return w;
      4'd1, 4'd11: return {8'hFF, w[23:0]};
      4'd2: begin
        r = int'(w[15:11]); g = int'(w[10:5]); b = int'(w[4:0]);
        return {8'hFF, 8'(r*8 + r/4), 8'(g*4 + g/16), 8'(b*8 + b/4)};
      end
      4'd3: begin
        a = w[15] ? 255 : 0;
        r = int'(w[14:10]); g = int'(w[9:5]); b = int'(w[4:0]);
        return {8'(a), 8'(r*8 + r/4), 8'(g*8 + g/4), 8'(b*8 + b/4)};
      end
      4'd4: return {8'(int'(w[15:12])*17), 8'(int'(w[11:8])*17),
                    8'(int'(w[7:4])*17), 8'(int'(w[3:0])*17)};
      4'd5: return lut_m[w[7:0]];
      4'd6: return {8'(int'(w[7:4])*17), lut_m[{4'd0, w[3:0]}][23:0]};
      4'd7: return {w[15:8], lut_m[w[7:0]][23:0]};
      4'd8: return lut_m[{4'd0, w[3:0]}];
      4'd9: return {8'(int'(w[3:0])*17), cfg_color};
      4'd10: return {w[7:0], cfg_color};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] fin(input logic [31:0] p);
    int a;
    a = int'(p[31:24]);
    if (cfg_amode == 2'd1) a = int'(cfg_alpha);
    else if (cfg_amode == 2'd2) a = (a * int'(cfg_alpha) + 127) / 255;
    if (cfg_ainv) a = 255 - a;
    if (cfg_rbswap) return {8'(a), p[7:0], p[15:8], p[23:16]};
    return {8'(a), p[23:0]};
  endfunction

  task automatic push(input logic [31:0] e, input string tag);
    exp_q[wr % 256] = e; tag_q[wr % 256] = tag; wr++;
  endtask

  task automatic send(input logic [31:0] w, input string tag);
    logic four;
    four = (cfg_fmt == 4'd8) || (cfg_fmt == 4'd9);
    if (four) begin
      push(fin(raw(cfg_fmt, {28'd0, w[3:0]})), tag);
      push(fin(raw(cfg_fmt, {28'd0, w[7:4]})), tag);
    end else push(fin(raw(cfg_fmt, w)), tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    #8;
    while (!in_ready) begin @(negedge clk); #8; end
    @(posedge clk);
    if (four) begin
      @(negedge clk); #8;
      chk("R5 stall after nibble word", {31'd0, in_ready}, 32'd0);
    end
  endtask

  task automatic drain;
    @(negedge clk); in_valid = 1'b0;
    while (wr != rd) @(negedge clk);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cpu_rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(posedge clk); @(negedge clk); cpu_en = 1'b0;
    d = cpu_rdata; e = cpu_err;
  endtask

  task automatic cpu_wr(input logic [7:0] a, input logic [31:0] v, output logic e);
    @(negedge clk); cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
    @(posedge clk); @(negedge clk); cpu_en = 1'b0; cpu_we = 1'b0;
    e = cpu_err;
  endtask

  task automatic load_lut(input logic [7:0] last, input logic rgb, input logic probe);
    logic [31:0] w, d0, d1;
    logic e;
    @(negedge clk); ld_start = 1'b1; ld_last = last; ld_rgb = rgb;
    @(posedge clk); @(negedge clk); ld_start = 1'b0;
    for (int i = 0; i <= int'(last); i++) begin
      if (probe && i == int'(last) / 2) begin
        chk("R11 busy mid-load", {31'd0, ld_busy}, 32'd1);
        in_valid = 1'b1; #8;
        chk("R11 input blocked during load", {31'd0, in_ready}, 32'd0);
        @(negedge clk); in_valid = 1'b0;
        ld_start = 1'b1; ld_last = 8'd3;
        @(posedge clk); @(negedge clk); ld_start = 1'b0;
        d0 = cpu_rdata;
        cpu_rd(8'd0, d1, e);
        chk("R12 read refused flag", {31'd0, e}, 32'd1);
        chk("R12 read data untouched", d1, d0);
        cpu_wr(8'd1, 32'hDEAD_BEEF, e);
        chk("R12 write refused flag", {31'd0, e}, 32'd1);
      end
      if (i == int'(last))
        chk("R11 busy before last word", {31'd0, ld_busy}, 32'd1);
      rnd(w);
      ld_valid = 1'b1; ld_data = w;
      lut_m[i] = rgb ? {8'hFF, w[23:0]} : w;
      @(posedge clk); @(negedge clk); ld_valid = 1'b0;
      if (w[0]) begin @(posedge clk); @(negedge clk); end
    end
    chk("R11 busy cleared after last", {31'd0, ld_busy}, 32'd0);
  endtask

  initial begin : monitor
    logic held_v;
    logic [31:0] held_d;
    held_v = 1'b0; held_d = '0;
    forever begin
      @(negedge clk);
      #5;
      rrng = rrng ^ (rrng << 13); rrng = rrng ^ (rrng >> 17); rrng = rrng ^ (rrng << 5);
      out_ready = (rrng[1:0] != 2'b00);
      #3;
      if (rst_n) begin
        if (held_v && out_valid) chk("R10 data held while stalled", out_data, held_d);
        held_v = out_valid && !out_ready;
        held_d = out_data;
        if (out_valid && out_ready) begin
          if (rd == wr) chk("R10 unexpected output", out_data, 32'hFFFF_FFFF ^ out_data);
          else begin
            chk(tag_q[rd % 256], out_data, exp_q[rd % 256]);
            rd++;
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] w, d;
    logic e;
    logic [7:0] ks [7];
    ks = '{8'd0, 8'd1, 8'd127, 8'd128, 8'd254, 8'd255, 8'h5A};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #8;
    chk("R13 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R13 ld_busy", {31'd0, ld_busy}, 32'd0);
    chk("R13 cpu_err", {31'd0, cpu_err}, 32'd0);
    chk("R13 in_ready", {31'd0, in_ready}, 32'd1);

    load_lut(8'd255, 1'b0, 1'b1);
    foreach (ks[j]) begin
      cpu_rd(ks[j], d, e);
      chk("R11 argb entry readback", d, lut_m[ks[j]]);
    end
    cpu_rd(8'd1, d, e);
    chk("R12 refused write left entry", d, lut_m[1]);
    cpu_wr(8'd200, 32'h1122_3344, e);
    lut_m[200] = 32'h1122_3344;
    chk("R12 idle write no flag", {31'd0, e}, 32'd0);
    cpu_rd(8'd200, d, e);
    chk("R12 idle write readback", d, 32'h1122_3344);

    for (int m = 0; m < 3; m++)
      for (int v = 0; v < 2; v++)
        for (int s = 0; s < 2; s++) begin
          cfg_amode = 2'(m); cfg_ainv = v[0]; cfg_rbswap = s[0]; cfg_alpha = 8'hA7;
          for (int f = 0; f < 12; f++) begin
            cfg_fmt = 4'(f);
            for (int n = 0; n < 24; n++) begin rnd(w); send(w, "R1/R3/R4/R6/R7/R8 combo"); end
            drain();
          end
        end

    cfg_amode = 2'd0; cfg_ainv = 1'b0; cfg_rbswap = 1'b0;
    for (int f = 2; f <= 4; f++) begin
      cfg_fmt = 4'(f);
      for (int v = 0; v < 65536; v += 37) send(32'(v), "R2 packed sweep");
      send(32'h0000_FFFF, "R2 full scale");
      drain();
    end
    foreach (ks[j]) begin
      cfg_fmt = 4'd7;
      for (int v = 0; v < 256; v++) send({16'd0, ks[j], 8'(v)}, "R3 wide alpha index");
      drain();
    end
    cfg_fmt = 4'd5;  for (int v = 0; v < 256; v++) send(32'(v), "R3 byte index");  drain();
    cfg_fmt = 4'd6;  for (int v = 0; v < 256; v++) send(32'(v), "R3 nibble alpha index"); drain();
    cfg_fmt = 4'd8;  for (int v = 0; v < 256; v++) send(32'(v), "R5 nibble index order"); drain();
    cfg_fmt = 4'd9;  for (int v = 0; v < 256; v++) send(32'(v), "R4 nibble alpha order"); drain();
    cfg_fmt = 4'd10; for (int v = 0; v < 256; v++) send(32'(v), "R4 byte alpha"); drain();

    cfg_amode = 2'd2;
    foreach (ks[j]) begin
      cfg_alpha = ks[j];
      for (int v = 0; v < 256; v++) send(32'(v), "R6 scale rounding");
      drain();
    end
    cfg_amode = 2'd3; cfg_alpha = 8'h10; cfg_fmt = 4'd0;
    for (int n = 0; n < 32; n++) begin rnd(w); send(w, "R6 mode 3 keeps"); end
    drain();

    for (int f = 12; f < 16; f++) begin
      cfg_fmt = 4'(f); cfg_amode = 2'(f - 12); cfg_ainv = f[0]; cfg_alpha = 8'h4B;
      for (int n = 0; n < 8; n++) begin rnd(w); send(w, "R9 invalid code"); end
      drain();
    end

    d = lut_m[16];
    load_lut(8'd15, 1'b1, 1'b0);
    cpu_rd(8'd0, w, e);  chk("R11 rgb entry 0", w, lut_m[0]);
    cpu_rd(8'd15, w, e); chk("R11 rgb entry 15", w, lut_m[15]);
    chk("R11 rgb entry alpha", {24'd0, w[31:24]}, 32'hFF);
    cpu_rd(8'd16, w, e); chk("R11 entry beyond last kept", w, d);
    cfg_amode = 2'd0; cfg_ainv = 1'b0; cfg_rbswap = 1'b1; cfg_fmt = 4'd8;
    for (int v = 0; v < 256; v++) send(32'(v), "R5/R11 nibble index rgb table");
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule